// File: doc/BRIEF.md
# Character Border and Shadow Generator

This block decorates one scan line of a character cell from a font that is 10 dots wide and 16 lines tall. For every dot clock it takes the font line being drawn, the line above it and the line below it, together with the dot column and the line number inside the cell. One dot clock later it returns two flags for that dot. The first flag says the font dot itself is lit. The second flag says the dot must be drawn as a black outline dot.

Two outline styles can be selected. The outline style draws black dots on all four sides of the lit font dots. The drop style draws black dots only to the right of lit dots and below them. A separate enable switches outlining off, and then the stream carries the plain font dots only. Font lookup, colour choice and height scaling happen upstream or downstream of this block.

Top module: `char_edge_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `fg_on` and `blk_on` are 0.
- R2: Both outputs are registered and refer to the inputs sampled at the previous rising clock edge. `fg_on` equals bit `dot_col` of `line_mid`. Bit 0 is the leftmost dot of the cell and bit 9 is the rightmost dot.
- R3: When `outline_en` is 0, `blk_on` is 0 and `fg_on` still follows the font.
- R4: When `drop_sel` is 0 (outline style), an unlit dot is marked black if any of these dots is lit: the dot to its left or right on the same line, the dot above it in `line_up`, or the dot below it in `line_dn`.
- R5: When `drop_sel` is 1 (drop style), an unlit dot is marked black only if the dot to its left on the same line or the dot above it in `line_up` is lit. Lit dots to its right or below it have no effect.
- R6: A lit font dot is never marked black. `fg_on` and `blk_on` are never both 1.
- R7: When `cell_line` is 0, `line_up` is treated as blank. When `cell_line` is 15, `line_dn` is treated as blank.
- R8: Dots outside the cell are treated as blank. Column 0 has no left neighbour and column 9 has no right neighbour. A `dot_col` of 10 or more gives 0 on both outputs.
- R9: When `dot_vld` is 0, both outputs are 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_vld | input | 1 | A dot is presented this cycle |
| dot_col | input | 4 | Column of the dot within the cell (0 to 9) |
| cell_line | input | 4 | Line of the cell being drawn (0 to 15) |
| line_up | input | 10 | Font line above the current line |
| line_mid | input | 10 | Font line being drawn |
| line_dn | input | 10 | Font line below the current line |
| outline_en | input | 1 | Enables black outline generation |
| drop_sel | input | 1 | 1 selects the drop style, 0 selects the four-sided outline |
| fg_on | output | 1 | The font dot is lit |
| blk_on | output | 1 | The dot is an outline dot, drawn black |

## Verification
Both flags for a dot are due exactly one rising edge after that dot's inputs are sampled. No result is due in the same cycle as its inputs, and none is due later than that one edge. The bench changes the inputs just after a rising edge. It compares the outputs against its own reference 1 ns after the following rising edge, while the next dot's inputs are still being set up. Directed cases check each neighbour direction in both styles, the first and last lines of the cell, the first and last columns, and columns out of range. Random dots then cover the combinations the directed cases leave out.

// File: rtl/char_edge_pkg.sv
package char_edge_pkg;
    parameter int unsigned FONT_W = 10;
    parameter int unsigned FONT_H = 16;
    localparam int unsigned COL_W  = $clog2(FONT_W);
    localparam int unsigned LINE_W = $clog2(FONT_H);

    typedef struct packed {
        logic fg_on;
        logic blk_on;
    } dot_flags_t;
endpackage

// File: rtl/edge_mask_gen.sv
module edge_mask_gen #(
    parameter int unsigned W = 10
) (
    input  logic [W-1:0] above,
    input  logic [W-1:0] mid,
    input  logic [W-1:0] below,
    input  logic         at_top,
    input  logic         at_bottom,
    output logic [W-1:0] ring_mask,
    output logic [W-1:0] drop_mask
);
    logic [W-1:0] above_v;
    logic [W-1:0] below_v;

    assign above_v = at_top    ? '0 : above;
    assign below_v = at_bottom ? '0 : below;

    for (genvar c = 0; c < W; c++) begin : g_col
        logic from_left;
        logic from_right;
        if (c > 0) begin : g_l
            assign from_left = mid[c-1];
        end else begin : g_nl
            assign from_left = 1'b0;
        end
        if (c < W - 1) begin : g_r
            assign from_right = mid[c+1];
        end else begin : g_nr
            assign from_right = 1'b0;
        end
        assign ring_mask[c] = from_left | from_right | above_v[c] | below_v[c];
        assign drop_mask[c] = from_left | above_v[c];
    end
endmodule

// File: rtl/dot_pick.sv
module dot_pick #(
    parameter int unsigned W  = 10,
    parameter int unsigned CW = 4
) (
    input  logic [W-1:0]  vec,
    input  logic [CW-1:0] sel,
    output logic          bit_o,
    output logic          in_range
);
    always_comb begin
        bit_o    = 1'b0;
        in_range = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (sel == CW'(i)) begin
                bit_o    = vec[i];
                in_range = 1'b1;
            end
        end
    end
endmodule

// File: rtl/char_edge_gen.sv
module char_edge_gen
    import char_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_vld,
    input  logic [COL_W-1:0]  dot_col,
    input  logic [LINE_W-1:0] cell_line,
    input  logic [FONT_W-1:0] line_up,
    input  logic [FONT_W-1:0] line_mid,
    input  logic [FONT_W-1:0] line_dn,
    input  logic              outline_en,
    input  logic              drop_sel,
    output logic              fg_on,
    output logic              blk_on
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(FONT_H - 1);

    logic [FONT_W-1:0] ring_mask;
    logic [FONT_W-1:0] drop_mask;
    logic [FONT_W-1:0] sel_mask;
    logic              font_bit;
    logic              mask_bit;
    logic              col_ok;
    logic              col_ok_unused;
    dot_flags_t        flags_d;
    dot_flags_t        flags_q;

    edge_mask_gen #(.W(FONT_W)) u_mask (
        .above    (line_up),
        .mid      (line_mid),
        .below    (line_dn),
        .at_top   (cell_line == '0),
        .at_bottom(cell_line == LAST_LINE),
        .ring_mask(ring_mask),
        .drop_mask(drop_mask)
    );

    assign sel_mask = drop_sel ? drop_mask : ring_mask;

    dot_pick #(.W(FONT_W), .CW(COL_W)) u_pick_font (
        .vec     (line_mid),
        .sel     (dot_col),
        .bit_o   (font_bit),
        .in_range(col_ok)
    );

    dot_pick #(.W(FONT_W), .CW(COL_W)) u_pick_mask (
        .vec     (sel_mask),
        .sel     (dot_col),
        .bit_o   (mask_bit),
        .in_range(col_ok_unused)
    );

    always_comb begin
        flags_d = '0;
        if (dot_vld && col_ok) begin
            flags_d.fg_on  = font_bit;
            flags_d.blk_on = outline_en && !font_bit && mask_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign fg_on  = flags_q.fg_on;
    assign blk_on = flags_q.blk_on;

    // R6: a lit dot wins over an outline mark
    a_r6_lit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        !(fg_on && blk_on));

    // R3: no outline when disabled
    a_r3_off_no_blk: assert property (@(posedge clk) disable iff (!rst_n)
        !outline_en |=> !blk_on);

    // R9: idle cycles give dark output
    a_r9_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        !dot_vld |=> (!fg_on && !blk_on));

    // R7: on the top line only the current and lower lines can mark a dot
    a_r7_top_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_line == '0 && line_mid == '0 && line_dn == '0) |=> !blk_on);

    // R8: out-of-range columns are dark
    a_r8_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_col >= COL_W'(FONT_W)) |=> (!fg_on && !blk_on));

    // R2: font flag follows the sampled line one cycle later
    a_r2_font_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (dot_vld && dot_col == '0) |=> (fg_on == $past(line_mid[0])));
endmodule

// File: tb/tb_char_edge_gen.sv
module tb_char_edge_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dot_vld = 1'b0;
    logic [3:0] dot_col = '0;
    logic [3:0] cell_line = '0;
    logic [9:0] line_up = '0;
    logic [9:0] line_mid = '0;
    logic [9:0] line_dn = '0;
    logic       outline_en = 1'b0;
    logic       drop_sel = 1'b0;
    logic       fg_on;
    logic       blk_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    char_edge_gen dut (
        .clk(clk), .rst_n(rst_n), .dot_vld(dot_vld), .dot_col(dot_col),
        .cell_line(cell_line), .line_up(line_up), .line_mid(line_mid),
        .line_dn(line_dn), .outline_en(outline_en), .drop_sel(drop_sel),
        .fg_on(fg_on), .blk_on(blk_on)
    );

    function automatic int lit(logic [9:0] v, int c);
        if (c < 0 || c > 9) return 0;
        return int'(v[c]);
    endfunction

    task automatic check(string req, int act_fg, int act_blk, int exp_fg, int exp_blk);
        checks++;
        if (act_fg != exp_fg || act_blk != exp_blk) begin
            errors++;
            $display("FAIL %s: fg/blk actual %0d/%0d expected %0d/%0d", req, act_fg, act_blk, exp_fg, exp_blk);
        end
    endtask

    // drive one dot, wait one edge, compare against the reference
    task automatic dot(string req, int v, int col, int ln, logic [9:0] up, logic [9:0] mid,
                       logic [9:0] dn, int en, int drop);
        int ef, eb, a, b;
        dot_vld = v[0]; dot_col = 4'(col); cell_line = 4'(ln);
        line_up = up; line_mid = mid; line_dn = dn;
        outline_en = en[0]; drop_sel = drop[0];
        ef = 0; eb = 0;
        if (v != 0 && col < 10) begin
            ef = lit(mid, col);
            a = (ln == 0) ? 0 : lit(up, col);
            b = (ln == 15) ? 0 : lit(dn, col);
            if (en != 0 && ef == 0) begin
                if (drop != 0) eb = (lit(mid, col - 1) | a);
                else           eb = (lit(mid, col - 1) | lit(mid, col + 1) | a | b);
            end
        end
        @(posedge clk); #1;
        check(req, int'(fg_on), int'(blk_on), ef, eb);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        line_mid = 10'h3FF; dot_vld = 1'b1; outline_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", int'(fg_on), int'(blk_on), 0, 0);
        dot_vld = 1'b0;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1", int'(fg_on), int'(blk_on), 0, 0);

        // R2 plain font and latency
        dot("R2", 1, 3, 5, '0, 10'b0000001000, '0, 1, 0);
        dot("R2", 1, 4, 5, '0, 10'b0000001000, '0, 0, 0);
        // R3 outline off
        dot("R3", 1, 4, 5, 10'h3FF, 10'b0000001000, 10'h3FF, 0, 0);
        // R4 outline from each side
        dot("R4", 1, 4, 5, '0, 10'b0000001000, '0, 1, 0);
        dot("R4", 1, 2, 5, '0, 10'b0000001000, '0, 1, 0);
        dot("R4", 1, 6, 5, 10'b0001000000, '0, '0, 1, 0);
        dot("R4", 1, 6, 5, '0, '0, 10'b0001000000, 1, 0);
        // R5 drop style: right and below marked, left and above not
        dot("R5", 1, 4, 5, '0, 10'b0000001000, '0, 1, 1);
        dot("R5", 1, 2, 5, '0, 10'b0000001000, '0, 1, 1);
        dot("R5", 1, 6, 5, 10'b0001000000, '0, '0, 1, 1);
        dot("R5", 1, 6, 5, '0, '0, 10'b0001000000, 1, 1);
        // R6 lit dot with lit neighbours
        dot("R6", 1, 5, 5, 10'h3FF, 10'h3FF, 10'h3FF, 1, 0);
        // R7 top and bottom lines
        dot("R7", 1, 1, 0, 10'h3FF, '0, '0, 1, 0);
        dot("R7", 1, 1, 15, '0, '0, 10'h3FF, 1, 0);
        dot("R7", 1, 1, 15, 10'h3FF, '0, '0, 1, 1);
        // R8 cell columns
        dot("R8", 1, 0, 5, '0, 10'b1000000000, '0, 1, 0);
        dot("R8", 1, 9, 5, '0, 10'b0000000001, '0, 1, 0);
        dot("R8", 1, 10, 5, 10'h3FF, 10'h3FF, 10'h3FF, 1, 0);
        dot("R8", 1, 15, 5, '0, 10'h000, 10'h3FF, 1, 0);
        // R9 idle
        dot("R9", 0, 3, 5, '0, 10'h3FF, '0, 1, 0);
        dot("R9", 0, 3, 5, 10'h3FF, '0, '0, 1, 0);

        for (int i = 0; i < 2000; i++) begin
            int v, c, l, e, d;
            v = ($urandom % 8 != 0) ? 1 : 0;
            c = $urandom % 12;
            l = $urandom % 16;
            e = $urandom % 2;
            d = $urandom % 2;
            dot("R4/R5 random", v, c, l, 10'($urandom), 10'($urandom), 10'($urandom), e, d);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule